// File: doc/BRIEF.md
# Dual-Queue Issue Scheduler

This block sits between dispatch and the execution units of an out-of-order core. Dispatch presents up to `DISP_W` operations per cycle. Each operation carries two source tags and one destination tag, plus a flag that sends it either to the integer queue or to the address queue. Only tags and readiness are tracked here. Operand values, arithmetic and the memory system live elsewhere.

The integer queue selects out of order. Each cycle it hands the oldest ready entries to the ALU issue ports, one entry per port. The address queue is a FIFO. It feeds a single load/store port and only ever offers its head entry.

A shared pending-tag table decides readiness. An operation is ready when none of its source tags is pending. Dispatching an operation marks its destination tag pending. A tag is cleared again in two ways:
- when its producer issues to an ALU, which models a single-cycle result;
- through external write-back ports, which carry load results.

Each queue reports its free-entry count to dispatch. A flush input empties both queues and clears all pending tags.

Top module: `dq_issue_sched`

## Requirements
- R1: Among ready integer entries, the oldest issues on ALU port 0 and the second oldest on port 1. Age follows dispatch order. `alu_valid_o[1]` is never high without `alu_valid_o[0]`.
- R2: An operation is ready only when each source tag is 0 or not pending. Dispatching an operation with a nonzero destination tag marks that tag pending from the next cycle on. If a pending mark and a clear hit the same tag in one cycle, the mark wins.
- R3: An integer operation issued on an ALU port in cycle t clears its destination tag. An operation depending on it may then issue in cycle t+1.
- R4: `wb_valid_i` with tag `wb_tag_i` in cycle t clears that tag. Operations waiting on it may issue in cycle t+1.
- R5: The address queue offers only its head entry, and only when the head's sources are ready. A non-ready head holds back every younger memory operation, even a ready one.
- R6: Lane l is captured when `disp_valid_i[l]` is high. `disp_mem_i[l]`=1 routes it to the address queue and 0 routes it to the integer queue. Lower lane numbers are older within a cycle. A captured entry can issue in the cycle after dispatch at the earliest.
- R7: `iq_free_o` and `aq_free_o` equal the queue depth minus the occupied entries. Entries issued or dispatched in cycle t are reflected in the count at cycle t+1. After reset both counts are full.
- R8: `flush_i` in cycle t empties both queues, clears every pending tag and discards the lanes dispatched in cycle t. In cycle t+1 both free counts are full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Empty both queues and clear all pending tags |
| disp_valid_i | input | DISP_W | Lane holds an operation |
| disp_mem_i | input | DISP_W | 1: address queue, 0: integer queue |
| disp_src1_i | input | DISP_W x TAG_W | First source tag per lane |
| disp_src2_i | input | DISP_W x TAG_W | Second source tag per lane |
| disp_dst_i | input | DISP_W x TAG_W | Destination tag per lane (0 = none) |
| wb_valid_i | input | EXT_WB | External result broadcast valid |
| wb_tag_i | input | EXT_WB x TAG_W | External result tag |
| alu_valid_o | output | NUM_ALU | ALU port carries an operation |
| alu_src1_o | output | NUM_ALU x TAG_W | First source tag of issued ALU op |
| alu_src2_o | output | NUM_ALU x TAG_W | Second source tag of issued ALU op |
| alu_dst_o | output | NUM_ALU x TAG_W | Destination tag of issued ALU op |
| mem_valid_o | output | 1 | Load/store port carries an operation |
| mem_src1_o | output | TAG_W | First source tag of memory op |
| mem_src2_o | output | TAG_W | Second source tag of memory op |
| mem_dst_o | output | TAG_W | Destination tag of memory op |
| iq_free_o | output | clog2(IQ_DEPTH+1) | Free integer queue entries |
| aq_free_o | output | clog2(AQ_DEPTH+1) | Free address queue entries |

## Verification
The assertions assume that dispatch respects the reported free counts: outside a flush cycle, no cycle sends more integer or memory lanes than the matching queue can take. They also assume that live destination tags are distinct, so a tag is never pending for two producers at once.

The stimulus keeps within both assumptions:
- every scenario begins on empty queues, right after a flush;
- no burst exceeds the reported space;
- each scenario uses fresh destination tags.

A sweep over every combination of lane valid bits and queue routing checks, one cycle after dispatch, the issue ports and the free counts. Directed sequences cover dependency chains, late write-back, a blocked address-queue head, a full integer queue and a flush that coincides with dispatch.

// File: rtl/dq_issue_pkg.sv
package dq_issue_pkg;
  localparam int unsigned TAG_W    = 5;
  localparam int unsigned NUM_TAGS = 1 << TAG_W;

  typedef logic [TAG_W-1:0] tag_t;

  typedef struct packed {
    tag_t src1;
    tag_t src2;
    tag_t dst;
  } uop_t;
endpackage

// File: rtl/dq_scoreboard.sv
module dq_scoreboard
  import dq_issue_pkg::*;
#(
  parameter int unsigned NUM_SET = 4,
  parameter int unsigned NUM_CLR = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     flush_i,
  input  logic [NUM_SET-1:0]       set_vld_i,
  input  tag_t [NUM_SET-1:0]       set_tag_i,
  input  logic [NUM_CLR-1:0]       clr_vld_i,
  input  tag_t [NUM_CLR-1:0]       clr_tag_i,
  output logic [NUM_TAGS-1:0]      busy_o
);
  logic [NUM_TAGS-1:0] busy_q, busy_d;

  always_comb begin
    busy_d = busy_q;
    for (int c = 0; c < int'(NUM_CLR); c++)
      if (clr_vld_i[c]) busy_d[clr_tag_i[c]] = 1'b0;
    // new producer wins over a clear of the same tag
    for (int s = 0; s < int'(NUM_SET); s++)
      if (set_vld_i[s]) busy_d[set_tag_i[s]] = 1'b1;
    busy_d[0] = 1'b0;
    if (flush_i) busy_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= '0;
    else         busy_q <= busy_d;
  end

  assign busy_o = busy_q;

  // R2
  set_mark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_vld_i[0] && !flush_i && set_tag_i[0] != '0) |=> busy_q[$past(set_tag_i[0])]);

  // R8
  flush_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (busy_q == '0));
endmodule

// File: rtl/dq_int_queue.sv
module dq_int_queue
  import dq_issue_pkg::*;
#(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned DISP_W  = 4,
  parameter int unsigned NUM_ALU = 2,
  localparam int unsigned CW = $clog2(DEPTH + 1),
  localparam int unsigned LW = (DISP_W > 1) ? $clog2(DISP_W) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  flush_i,
  input  logic [DISP_W-1:0]     alloc_i,
  input  uop_t [DISP_W-1:0]     op_i,
  input  logic [NUM_TAGS-1:0]   busy_i,
  output logic [NUM_ALU-1:0]    iss_vld_o,
  output uop_t [NUM_ALU-1:0]    iss_op_o,
  output logic [CW-1:0]         free_o
);
  logic [DEPTH-1:0] vld_q, rdy, issued, alloc_oh, taken;
  logic [DEPTH-1:0] older_q [DEPTH];
  logic [DEPTH-1:0] slot_oh [DISP_W];
  logic [LW-1:0]    lane_of [DEPTH];
  uop_t             alloc_op [DEPTH];
  uop_t             op_q [DEPTH];
  int               older_rdy [DEPTH];

  // readiness and rank among ready entries
  always_comb begin
    for (int i = 0; i < int'(DEPTH); i++)
      rdy[i] = vld_q[i] && !busy_i[op_q[i].src1] && !busy_i[op_q[i].src2];
    for (int i = 0; i < int'(DEPTH); i++) begin
      older_rdy[i] = $countones(older_q[i] & rdy);
      issued[i]    = rdy[i] && (older_rdy[i] < int'(NUM_ALU));
    end
  end

  // port p takes the entry with exactly p older ready entries
  always_comb begin
    iss_vld_o = '0;
    iss_op_o  = '0;
    for (int p = 0; p < int'(NUM_ALU); p++)
      for (int i = 0; i < int'(DEPTH); i++)
        if (rdy[i] && older_rdy[i] == p) begin
          iss_vld_o[p] = 1'b1;
          iss_op_o[p]  = op_q[i];
        end
  end

  // lowest free slot per dispatch lane, in lane order
  always_comb begin
    taken    = vld_q;
    alloc_oh = '0;
    for (int i = 0; i < int'(DEPTH); i++) begin
      lane_of[i]  = '0;
      alloc_op[i] = '0;
    end
    for (int l = 0; l < int'(DISP_W); l++) begin
      slot_oh[l] = '0;
      if (alloc_i[l])
        for (int i = int'(DEPTH) - 1; i >= 0; i--)
          if (!taken[i]) begin
            slot_oh[l]    = '0;
            slot_oh[l][i] = 1'b1;
          end
      taken    = taken | slot_oh[l];
      alloc_oh = alloc_oh | slot_oh[l];
      for (int i = 0; i < int'(DEPTH); i++)
        if (slot_oh[l][i]) begin
          lane_of[i]  = LW'(l);
          alloc_op[i] = op_i[l];
        end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int r = 0; r < int'(DEPTH); r++) older_q[r] <= '0;
    end else begin
      if (flush_i) vld_q <= '0;
      else         vld_q <= (vld_q & ~issued) | alloc_oh;
      for (int r = 0; r < int'(DEPTH); r++)
        for (int c = 0; c < int'(DEPTH); c++) begin
          if (alloc_oh[r])
            older_q[r][c] <= vld_q[c] | (alloc_oh[c] && (lane_of[c] < lane_of[r]));
          else if (alloc_oh[c])
            older_q[r][c] <= 1'b0;
        end
    end
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < int'(DEPTH); i++)
      if (alloc_oh[i]) op_q[i] <= alloc_op[i];
  end

  assign free_o = CW'(int'(DEPTH) - $countones(vld_q));

  // R7
  iq_acct_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i |=> (int'(free_o) == int'($past(free_o)) + $countones($past(issued))
                                  - $countones($past(alloc_oh))));

  // R8
  iq_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (free_o == CW'(DEPTH)));
endmodule

// File: rtl/dq_addr_queue.sv
module dq_addr_queue
  import dq_issue_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DISP_W = 4,
  localparam int unsigned CW = $clog2(DEPTH + 1),
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  flush_i,
  input  logic [DISP_W-1:0]     push_i,
  input  uop_t [DISP_W-1:0]     op_i,
  input  logic [NUM_TAGS-1:0]   busy_i,
  output logic                  iss_vld_o,
  output uop_t                  iss_op_o,
  output logic [CW-1:0]         free_o
);
  logic [PW-1:0] head_q, tail_q;
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] widx [DISP_W];
  int            npush;
  uop_t          ent_q [DEPTH];

  function automatic logic [PW-1:0] ptr_add(input logic [PW-1:0] p, input int n);
    int s;
    s = int'(p) + n;
    if (s >= int'(DEPTH)) s = s - int'(DEPTH);
    return PW'(s);
  endfunction

  always_comb begin
    npush = 0;
    for (int l = 0; l < int'(DISP_W); l++) begin
      widx[l] = ptr_add(tail_q, npush);
      if (push_i[l]) npush = npush + 1;
    end
  end

  assign iss_op_o  = ent_q[head_q];
  assign iss_vld_o = (cnt_q != '0) && !busy_i[iss_op_o.src1] && !busy_i[iss_op_o.src2];
  assign free_o    = CW'(DEPTH) - cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (iss_vld_o) head_q <= ptr_add(head_q, 1);
      tail_q <= ptr_add(tail_q, npush);
      cnt_q  <= CW'(int'(cnt_q) + npush - int'(iss_vld_o));
    end
  end

  always_ff @(posedge clk_i) begin
    for (int l = 0; l < int'(DISP_W); l++)
      if (push_i[l]) ent_q[widx[l]] <= op_i[l];
  end

  // R5
  in_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_vld_o && !flush_i) |=> (head_q == ptr_add($past(head_q), 1)));

  // R7
  aq_acct_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i |=> (int'(cnt_q) == int'($past(cnt_q)) + $countones($past(push_i))
                                  - int'($past(iss_vld_o))));
endmodule

// File: rtl/dq_issue_sched.sv
module dq_issue_sched
  import dq_issue_pkg::*;
#(
  parameter int unsigned DISP_W   = 4,
  parameter int unsigned IQ_DEPTH = 8,
  parameter int unsigned AQ_DEPTH = 8,
  parameter int unsigned NUM_ALU  = 2,
  parameter int unsigned EXT_WB   = 1,
  localparam int unsigned IQ_CW = $clog2(IQ_DEPTH + 1),
  localparam int unsigned AQ_CW = $clog2(AQ_DEPTH + 1)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              flush_i,
  input  logic [DISP_W-1:0]                 disp_valid_i,
  input  logic [DISP_W-1:0]                 disp_mem_i,
  input  logic [DISP_W-1:0][TAG_W-1:0]      disp_src1_i,
  input  logic [DISP_W-1:0][TAG_W-1:0]      disp_src2_i,
  input  logic [DISP_W-1:0][TAG_W-1:0]      disp_dst_i,
  input  logic [EXT_WB-1:0]                 wb_valid_i,
  input  logic [EXT_WB-1:0][TAG_W-1:0]      wb_tag_i,
  output logic [NUM_ALU-1:0]                alu_valid_o,
  output logic [NUM_ALU-1:0][TAG_W-1:0]     alu_src1_o,
  output logic [NUM_ALU-1:0][TAG_W-1:0]     alu_src2_o,
  output logic [NUM_ALU-1:0][TAG_W-1:0]     alu_dst_o,
  output logic                              mem_valid_o,
  output logic [TAG_W-1:0]                  mem_src1_o,
  output logic [TAG_W-1:0]                  mem_src2_o,
  output logic [TAG_W-1:0]                  mem_dst_o,
  output logic [IQ_CW-1:0]                  iq_free_o,
  output logic [AQ_CW-1:0]                  aq_free_o
);
  localparam int unsigned NUM_CLR = NUM_ALU + EXT_WB;

  uop_t [DISP_W-1:0]   lane_op;
  uop_t [NUM_ALU-1:0]  alu_op;
  uop_t                mem_op;
  logic [DISP_W-1:0]   int_alloc, mem_push;
  logic [NUM_TAGS-1:0] busy;
  logic [NUM_CLR-1:0]  clr_vld;
  tag_t [NUM_CLR-1:0]  clr_tag;

  always_comb begin
    for (int l = 0; l < int'(DISP_W); l++) begin
      lane_op[l].src1 = disp_src1_i[l];
      lane_op[l].src2 = disp_src2_i[l];
      lane_op[l].dst  = disp_dst_i[l];
    end
  end

  assign int_alloc = disp_valid_i & ~disp_mem_i & {DISP_W{~flush_i}};
  assign mem_push  = disp_valid_i &  disp_mem_i & {DISP_W{~flush_i}};

  // single-cycle ALU results wake their consumers directly
  always_comb begin
    for (int p = 0; p < int'(NUM_ALU); p++) begin
      clr_vld[p] = alu_valid_o[p];
      clr_tag[p] = alu_op[p].dst;
    end
    for (int w = 0; w < int'(EXT_WB); w++) begin
      clr_vld[int'(NUM_ALU) + w] = wb_valid_i[w];
      clr_tag[int'(NUM_ALU) + w] = wb_tag_i[w];
    end
  end

  dq_scoreboard #(
    .NUM_SET(DISP_W),
    .NUM_CLR(NUM_CLR)
  ) u_sb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush_i),
    .set_vld_i (disp_valid_i),
    .set_tag_i (disp_dst_i),
    .clr_vld_i (clr_vld),
    .clr_tag_i (clr_tag),
    .busy_o    (busy)
  );

  dq_int_queue #(
    .DEPTH  (IQ_DEPTH),
    .DISP_W (DISP_W),
    .NUM_ALU(NUM_ALU)
  ) u_iq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flush_i  (flush_i),
    .alloc_i  (int_alloc),
    .op_i     (lane_op),
    .busy_i   (busy),
    .iss_vld_o(alu_valid_o),
    .iss_op_o (alu_op),
    .free_o   (iq_free_o)
  );

  dq_addr_queue #(
    .DEPTH (AQ_DEPTH),
    .DISP_W(DISP_W)
  ) u_aq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flush_i  (flush_i),
    .push_i   (mem_push),
    .op_i     (lane_op),
    .busy_i   (busy),
    .iss_vld_o(mem_valid_o),
    .iss_op_o (mem_op),
    .free_o   (aq_free_o)
  );

  always_comb begin
    for (int p = 0; p < int'(NUM_ALU); p++) begin
      alu_src1_o[p] = alu_op[p].src1;
      alu_src2_o[p] = alu_op[p].src2;
      alu_dst_o[p]  = alu_op[p].dst;
    end
  end

  assign mem_src1_o = mem_op.src1;
  assign mem_src2_o = mem_op.src2;
  assign mem_dst_o  = mem_op.dst;

  // R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i |-> ($countones(disp_valid_i & ~disp_mem_i) <= int'(iq_free_o)));

  // R6
  aq_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i |-> ($countones(disp_valid_i & disp_mem_i) <= int'(aq_free_o)));

  // R3
  alu_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_valid_o[0] && !flush_i && disp_valid_i == '0) |=> !busy[$past(alu_dst_o[0])]);

  if (NUM_ALU > 1) begin : g_order
    // R1
    alu_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      alu_valid_o[1] |-> alu_valid_o[0]);
  end
endmodule

// File: tb/dq_issue_sched_tb_top.sv
`timescale 1ns/1ps
module dq_issue_sched_tb_top;
  import dq_issue_pkg::*;

  localparam int DW = 4;
  localparam int QD = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic flush_i;
  logic [DW-1:0] disp_valid_i, disp_mem_i;
  logic [DW-1:0][TAG_W-1:0] disp_src1_i, disp_src2_i, disp_dst_i;
  logic [0:0] wb_valid_i;
  logic [0:0][TAG_W-1:0] wb_tag_i;
  logic [1:0] alu_valid_o;
  logic [1:0][TAG_W-1:0] alu_src1_o, alu_src2_o, alu_dst_o;
  logic mem_valid_o;
  logic [TAG_W-1:0] mem_src1_o, mem_src2_o, mem_dst_o;
  logic [3:0] iq_free_o, aq_free_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  dq_issue_sched dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i),
    .disp_valid_i(disp_valid_i), .disp_mem_i(disp_mem_i),
    .disp_src1_i(disp_src1_i), .disp_src2_i(disp_src2_i), .disp_dst_i(disp_dst_i),
    .wb_valid_i(wb_valid_i), .wb_tag_i(wb_tag_i),
    .alu_valid_o(alu_valid_o), .alu_src1_o(alu_src1_o), .alu_src2_o(alu_src2_o),
    .alu_dst_o(alu_dst_o), .mem_valid_o(mem_valid_o), .mem_src1_o(mem_src1_o),
    .mem_src2_o(mem_src2_o), .mem_dst_o(mem_dst_o),
    .iq_free_o(iq_free_o), .aq_free_o(aq_free_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic clr_in();
    flush_i = 1'b0;
    disp_valid_i = '0; disp_mem_i = '0;
    disp_src1_i = '0; disp_src2_i = '0; disp_dst_i = '0;
    wb_valid_i = '0; wb_tag_i = '0;
  endtask

  task automatic lane(input int l, input bit mem, input int s1, input int d);
    disp_valid_i[l] = 1'b1;
    disp_mem_i[l]   = mem;
    disp_src1_i[l]  = TAG_W'(s1);
    disp_src2_i[l]  = '0;
    disp_dst_i[l]   = TAG_W'(d);
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
    clr_in();
  endtask

  task automatic do_flush();
    flush_i = 1'b1;
    step();
  endtask

  // port 0 / port 1 destinations, zero when the port is idle
  function automatic logic [9:0] alu_dsts();
    return {alu_valid_o[1] ? alu_dst_o[1] : 5'd0, alu_valid_o[0] ? alu_dst_o[0] : 5'd0};
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    clr_in();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R7 reset state
    chk("R7 reset", {iq_free_o, aq_free_o, alu_valid_o, mem_valid_o}, {4'd8, 4'd8, 2'b00, 1'b0});

    // R1 four independent int ops, two per cycle, oldest first
    for (int l = 0; l < 4; l++) lane(l, 1'b0, 0, l + 1);
    step();
    chk("R1 first pair", {alu_valid_o, alu_dsts()}, {2'b11, 5'd2, 5'd1});
    chk("R7 count after dispatch", iq_free_o, 4'd4);
    step();
    chk("R1 second pair", {alu_valid_o, alu_dsts()}, {2'b11, 5'd4, 5'd3});
    chk("R7 count after issue", iq_free_o, 4'd6);
    step();
    chk("R7 drained", {alu_valid_o, iq_free_o}, {2'b00, 4'd8});
    do_flush();

    // R2 R3 dependency chain 5 -> 6 -> 7 issues one per cycle
    lane(0, 1'b0, 0, 5); lane(1, 1'b0, 5, 6); lane(2, 1'b0, 6, 7);
    step();
    chk("R2 chain head only", {alu_valid_o, alu_dsts()}, {2'b01, 5'd0, 5'd5});
    step();
    chk("R3 chain second", {alu_valid_o, alu_dsts()}, {2'b01, 5'd0, 5'd6});
    step();
    chk("R3 chain third", {alu_valid_o, alu_dsts()}, {2'b01, 5'd0, 5'd7});
    step();
    chk("R3 chain done", alu_valid_o, 2'b00);
    do_flush();

    // R1 R4 blocked older op wins once its load result arrives
    lane(0, 1'b1, 0, 10); lane(1, 1'b0, 10, 11); lane(2, 1'b0, 0, 12); lane(3, 1'b0, 0, 13);
    step();
    chk("R5 load issues", {mem_valid_o, mem_dst_o}, {1'b1, 5'd10});
    chk("R2 skip blocked", {alu_valid_o, alu_dsts()}, {2'b11, 5'd13, 5'd12});
    lane(0, 1'b0, 0, 14);
    wb_valid_i[0] = 1'b1; wb_tag_i[0] = 5'd10;
    step();
    chk("R4 R1 woken oldest first", {alu_valid_o, alu_dsts()}, {2'b11, 5'd14, 5'd11});
    do_flush();

    // R5 head blocks a ready younger memory op
    lane(0, 1'b1, 0, 20); lane(1, 1'b1, 20, 22); lane(2, 1'b1, 0, 23);
    step();
    chk("R5 head issues", {mem_valid_o, mem_dst_o, aq_free_o}, {1'b1, 5'd20, 4'd5});
    step();
    chk("R5 blocked head", {mem_valid_o, aq_free_o}, {1'b0, 4'd6});
    step();
    chk("R5 still blocked", mem_valid_o, 1'b0);
    wb_valid_i[0] = 1'b1; wb_tag_i[0] = 5'd20;
    step();
    chk("R4 R5 head released", {mem_valid_o, mem_dst_o}, {1'b1, 5'd22});
    step();
    chk("R5 younger follows", {mem_valid_o, mem_dst_o}, {1'b1, 5'd23});
    step();
    chk("R7 aq drained", {mem_valid_o, aq_free_o}, {1'b0, 4'd8});
    do_flush();

    // R7 fill integer queue with waiting ops, then R8 flush with dispatch
    lane(0, 1'b1, 0, 30);
    step();
    for (int l = 0; l < 4; l++) lane(l, 1'b0, 30, l + 1);
    step();
    for (int l = 0; l < 4; l++) lane(l, 1'b0, 30, l + 5);
    step();
    chk("R7 iq full", {iq_free_o, aq_free_o, alu_valid_o}, {4'd0, 4'd8, 2'b00});
    lane(0, 1'b0, 0, 9); lane(1, 1'b1, 0, 15);
    do_flush();
    chk("R8 flush empties", {iq_free_o, aq_free_o, alu_valid_o, mem_valid_o},
        {4'd8, 4'd8, 2'b00, 1'b0});
    lane(0, 1'b0, 30, 12);
    step();
    chk("R8 pending cleared", {alu_valid_o, alu_dsts()}, {2'b01, 5'd0, 5'd12});
    do_flush();

    // R1 R6 R7 sweep over lane valid and routing patterns
    for (int v = 0; v < 16; v++) begin
      for (int k = 0; k < 16; k++) begin
        int nint, nmem;
        logic [4:0] e0, e1, em;
        nint = 0; nmem = 0; e0 = '0; e1 = '0; em = '0;
        for (int l = 0; l < 4; l++) begin
          if (v[l]) begin
            lane(l, k[l], 0, l + 1);
            if (k[l]) begin
              if (nmem == 0) em = 5'(l + 1);
              nmem++;
            end else begin
              if (nint == 0) e0 = 5'(l + 1);
              else if (nint == 1) e1 = 5'(l + 1);
              nint++;
            end
          end
        end
        step();
        chk("R1 R6 R7 sweep",
            {alu_valid_o, alu_dsts(), mem_valid_o, mem_valid_o ? mem_dst_o : 5'd0, iq_free_o, aq_free_o},
            {(nint >= 2) ? 2'b11 : (nint == 1) ? 2'b01 : 2'b00, e1, e0, nmem > 0, em,
             4'(8 - nint), 4'(8 - nmem)});
        do_flush();
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule